// File: doc/BRIEF.md
# Real-Time-Clock Timebase with Resettable Divider

This block turns a crystal-rate tick enable (nominally 32.768 kHz, one `tickEn` pulse per crystal period) into a once-per-second update strobe. Each strobe advances a seconds counter. The divider is a binary counter `DIV_W` bits wide, so one update occurs per 2^DIV_W ticks. A small byte-wide register port gives software access to a control register and to the seconds register.

A three-bit divider-control field sits in the control register. One code lets the divider run. Two codes hold the divider parked at its midpoint. The remaining codes freeze it where it stands. Software sets the time precisely in four steps: read the control register, write it back with a hold code ORed in, load the seconds, then restore the saved value. Because the divider waited at its midpoint, the first update comes exactly half a period after the release. This lets the clock be aligned to an external second boundary.

Top module: `rtc_timebase`

## Requirements
- R1: After reset the control register reads 0x20 (field 010, running), the seconds register reads 0, the divider is at 0 and `updatePulse` is low.
- R2: With field code 010, the divider advances once per clock in which `tickEn` is high and produces one update per 2^DIV_W ticks. Clocks with `tickEn` low have no effect.
- R3: Field codes 110 and 111 behave the same. The divider is held at its midpoint 2^(DIV_W-1), and no update occurs however many ticks arrive.
- R4: After the field changes from a hold code to 010, the first update occurs on exactly the 2^(DIV_W-1)-th tick.
- R5: Field codes 000, 001, 011, 100 and 101 freeze the divider at its present count with no updates. On a return to 010, counting resumes from that count.
- R6: `updatePulse` is high for exactly one clock per update. It is high in the same cycle that the new seconds value first appears.
- R7: Each update increments the seconds counter, which wraps from 59 to 0. A stored value above 59 also becomes 0 on the next update.
- R8: The seconds register is at index 0x00 and holds 6 bits (bits 5:0 of the write data). It reads back zero-extended. A write that coincides with an update takes priority over the increment, and the pulse still fires.
- R9: The control register is at index 0x0A. Bits 6:4 form the divider field and bits 3:0 are plain storage with no effect on timing. Bit 7 always reads 0.
- R10: Reads of any other index return 0, and writes to any other index change neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | One-clock enable per crystal period |
| regWr | input | 1 | Register write strobe |
| regAddr | input | ADDR_W | Register index |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Read data for `regAddr` (combinational) |
| updatePulse | output | 1 | One-clock once-per-period update strobe |
| seconds | output | 6 | Current seconds count |

## Verification
The bench aims at the release boundary. It applies one tick short of half a period and then exactly half a period. A design that released from zero, or that added an extra register stage, would update late or never within the window. It runs the two hold codes against the five idle codes and then resumes. A design that parked the idle codes at the midpoint, or let them count, would update at the wrong tick. It also collides a seconds write with the rollover tick and loads 58 and 59 to cross the wrap. A design with the wrong priority or an off-by-one wrap would show a wrong seconds value at the port.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  localparam logic [2:0] CODE_RUN = 3'b010;
  localparam logic [5:0] SEC_LAST = 6'd59;

  typedef struct packed {
    logic       divRun;
    logic       divHold;
    logic       secLoad;
    logic [5:0] secData;
  } ctrlStrobes_t;

  function automatic logic isHoldCode(input logic [2:0] code);
    return code[2:1] == 2'b11;
  endfunction

endpackage

// File: rtl/rtc_ctrl.sv
module rtc_ctrl
  import rtc_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [7:0]        regWrData,
  input  logic [5:0]        seconds,
  output logic [2:0]        ctrlField,
  output ctrlStrobes_t      strb,
  output logic [7:0]        regRdData
);

  localparam logic [ADDR_W-1:0] CTRL_IDX = ADDR_W'(8'h0A);
  localparam logic [ADDR_W-1:0] SEC_IDX  = ADDR_W'(8'h00);
  localparam logic [6:0]        CTRL_RST = 7'h20;

  logic [6:0] ctrlReg;
  logic       unusedWrBit;

  assign unusedWrBit = regWrData[7];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg <= CTRL_RST;
    end else if (regWr && regAddr == CTRL_IDX) begin
      ctrlReg <= regWrData[6:0];
    end
  end

  assign ctrlField = ctrlReg[6:4];

  always_comb begin
    strb.divRun  = (ctrlField == CODE_RUN);
    strb.divHold = isHoldCode(ctrlField);
    strb.secLoad = regWr && (regAddr == SEC_IDX);
    strb.secData = regWrData[5:0];
  end

  always_comb begin
    if (regAddr == CTRL_IDX) begin
      regRdData = {1'b0, ctrlReg};
    end else if (regAddr == SEC_IDX) begin
      regRdData = {2'b00, seconds};
    end else begin
      regRdData = 8'h00;
    end
  end

endmodule

// File: rtl/rtc_datapath.sv
module rtc_datapath
  import rtc_pkg::*;
#(
  parameter int DIV_W = 15
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickEn,
  input  ctrlStrobes_t     strb,
  output logic [DIV_W-1:0] divCnt,
  output logic [5:0]       seconds,
  output logic             updatePulse
);

  localparam logic [DIV_W-1:0] DIV_MID  = {1'b1, {(DIV_W-1){1'b0}}};
  localparam logic [DIV_W-1:0] DIV_LAST = '1;

  logic       rollover;
  logic [5:0] secNext;

  assign rollover = strb.divRun && tickEn && (divCnt == DIV_LAST);
  assign secNext  = (seconds >= SEC_LAST) ? 6'd0 : seconds + 6'd1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divCnt <= '0;
    end else if (strb.divHold) begin
      divCnt <= DIV_MID;
    end else if (strb.divRun && tickEn) begin
      divCnt <= divCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      seconds     <= '0;
      updatePulse <= 1'b0;
    end else begin
      updatePulse <= rollover;
      if (strb.secLoad) begin
        seconds <= strb.secData;
      end else if (rollover) begin
        seconds <= secNext;
      end
    end
  end

endmodule

// File: rtl/rtc_timebase.sv
module rtc_timebase
  import rtc_pkg::*;
#(
  parameter int DIV_W  = 15,
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              regWr,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [7:0]        regWrData,
  output logic [7:0]        regRdData,
  output logic              updatePulse,
  output logic [5:0]        seconds
);

  ctrlStrobes_t     strb;
  logic [2:0]       ctrlField;
  logic [DIV_W-1:0] divCnt;

  rtc_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .regWr     (regWr),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .seconds   (seconds),
    .ctrlField (ctrlField),
    .strb      (strb),
    .regRdData (regRdData)
  );

  rtc_datapath #(.DIV_W(DIV_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .tickEn      (tickEn),
    .strb        (strb),
    .divCnt      (divCnt),
    .seconds     (seconds),
    .updatePulse (updatePulse)
  );

endmodule

// File: rtl/rtc_timebase_chk.sv
module rtc_timebase_chk #(
  parameter int DIV_W  = 15,
  parameter int ADDR_W = 7
) (
  input logic              clk,
  input logic              rstN,
  input logic              tickEn,
  input logic              regWr,
  input logic [ADDR_W-1:0] regAddr,
  input logic [7:0]        regRdData,
  input logic              updatePulse,
  input logic [5:0]        seconds,
  input logic [2:0]        ctrlField,
  input logic [DIV_W-1:0]  divCnt
);

  localparam logic [DIV_W-1:0]  MID      = {1'b1, {(DIV_W-1){1'b0}}};
  localparam logic [ADDR_W-1:0] CTRL_IDX = ADDR_W'(8'h0A);
  localparam logic [ADDR_W-1:0] SEC_IDX  = ADDR_W'(8'h00);

  logic holdNow;
  logic idleNow;
  assign holdNow = (ctrlField[2:1] == 2'b11);
  assign idleNow = (ctrlField != 3'b010) && !holdNow;

  // R2
  no_tick_no_move_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!tickEn && !holdNow) |=> ($stable(divCnt) && !updatePulse));

  // R3
  hold_parks_mid_chk: assert property (@(posedge clk) disable iff (!rstN)
    holdNow |=> (divCnt == MID && !updatePulse));

  // R5
  idle_freezes_chk: assert property (@(posedge clk) disable iff (!rstN)
    idleNow |=> ($stable(divCnt) && !updatePulse));

  // R6
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    updatePulse |=> !updatePulse);

  // R7
  sec_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (updatePulse && !$past(regWr && regAddr == SEC_IDX)) |->
      (seconds == (($past(seconds) >= 6'd59) ? 6'd0 : $past(seconds) + 6'd1)));

  // R9
  ctrl_top_bit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == CTRL_IDX) |-> !regRdData[7]);

  // R10
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr != CTRL_IDX && regAddr != SEC_IDX) |-> (regRdData == 8'h00));

endmodule

bind rtc_timebase rtc_timebase_chk #(.DIV_W(DIV_W), .ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .tickEn      (tickEn),
  .regWr       (regWr),
  .regAddr     (regAddr),
  .regRdData   (regRdData),
  .updatePulse (updatePulse),
  .seconds     (seconds),
  .ctrlField   (ctrlField),
  .divCnt      (divCnt)
);

// File: tb/rtc_timebase_bench.sv
module rtc_timebase_bench;

  localparam int DIV_W  = 6;
  localparam int ADDR_W = 7;
  localparam int FULL   = 1 << DIV_W;
  localparam int HALF   = 1 << (DIV_W - 1);
  localparam int NVEC   = 14;

  // {startSec[6], code[3], sparse[1], ticks[16], expSec[6]}
  localparam logic [31:0] VEC [NVEC] = '{
    {6'd5,  3'b010, 1'b0, 16'd31,  6'd5},
    {6'd5,  3'b010, 1'b0, 16'd32,  6'd6},
    {6'd5,  3'b010, 1'b1, 16'd95,  6'd6},
    {6'd5,  3'b010, 1'b0, 16'd96,  6'd7},
    {6'd59, 3'b010, 1'b0, 16'd32,  6'd0},
    {6'd58, 3'b010, 1'b1, 16'd96,  6'd0},
    {6'd20, 3'b110, 1'b0, 16'd200, 6'd20},
    {6'd20, 3'b111, 1'b0, 16'd200, 6'd20},
    {6'd20, 3'b000, 1'b0, 16'd100, 6'd20},
    {6'd20, 3'b001, 1'b0, 16'd100, 6'd20},
    {6'd20, 3'b011, 1'b0, 16'd100, 6'd20},
    {6'd20, 3'b100, 1'b0, 16'd100, 6'd20},
    {6'd20, 3'b101, 1'b0, 16'd100, 6'd20},
    {6'd0,  3'b010, 1'b1, 16'd160, 6'd3}
  };

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              tickEn = 1'b0;
  logic              regWr = 1'b0;
  logic [ADDR_W-1:0] regAddr = '0;
  logic [7:0]        regWrData = '0;
  logic [7:0]        regRdData;
  logic              updatePulse;
  logic [5:0]        seconds;

  int nChk  = 0;
  int nFail = 0;

  always #10 clk = ~clk;

  rtc_timebase #(.DIV_W(DIV_W), .ADDR_W(ADDR_W)) u_rtc_timebase (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .regWr(regWr), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .updatePulse(updatePulse),
    .seconds(seconds)
  );

  task automatic check(input string tag, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  endtask

  task automatic wrReg(input int addr, input int data);
    regWr = 1'b1; regAddr = ADDR_W'(addr); regWrData = 8'(data);
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic rdReg(input int addr, output int data);
    regAddr = ADDR_W'(addr);
    #1;
    data = int'(regRdData);
  endtask

  task automatic ticks(input int n, input bit sparse);
    for (int i = 0; i < n; i++) begin
      tickEn = 1'b1;
      @(negedge clk);
      tickEn = 1'b0;
      if (sparse) @(negedge clk);
    end
  endtask

  function automatic string tagFor(input logic [2:0] code);
    if (code == 3'b010) return "R4/R2/R7";
    if (code[2:1] == 2'b11) return "R3";
    return "R5";
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    int rd;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    rdReg(8'h0A, rd); check("R1 ctrl", rd, 8'h20);
    rdReg(8'h00, rd); check("R1 seconds", rd, 0);
    check("R1 pulse", int'(updatePulse), 0);

    // R6 full period from reset: pulse coincides with seconds change
    ticks(FULL - 1, 1'b0);
    check("R2 before full period", int'(seconds), 0);
    check("R6 no early pulse", int'(updatePulse), 0);
    ticks(1, 1'b0);
    check("R2 full period", int'(seconds), 1);
    check("R6 pulse with change", int'(updatePulse), 1);
    @(negedge clk);
    check("R6 pulse one clock", int'(updatePulse), 0);

    // table walk
    for (int v = 0; v < NVEC; v++) begin
      logic [5:0] st  = VEC[v][31:26];
      logic [2:0] cd  = VEC[v][25:23];
      logic       sp  = VEC[v][22];
      int         n   = int'(VEC[v][21:6]);
      logic [5:0] ex  = VEC[v][5:0];
      wrReg(8'h0A, 8'h70);
      wrReg(8'h00, int'(st));
      wrReg(8'h0A, int'({1'b0, cd, 4'h0}));
      ticks(n, sp);
      rdReg(8'h00, rd);
      check($sformatf("%s vec%0d", tagFor(cd), v), rd, int'(ex));
    end

    // R5 idle code freezes count and resumes from it
    wrReg(8'h0A, 8'h70);
    wrReg(8'h00, 10);
    wrReg(8'h0A, 8'h20);
    ticks(10, 1'b0);
    wrReg(8'h0A, 8'h00);
    ticks(100, 1'b0);
    check("R5 idle no update", int'(seconds), 10);
    wrReg(8'h0A, 8'h20);
    ticks(HALF - 11, 1'b0);
    check("R5 resume not early", int'(seconds), 10);
    ticks(1, 1'b0);
    check("R5 resume from frozen count", int'(seconds), 11);

    // R8 write coincident with rollover wins, pulse still fires
    wrReg(8'h0A, 8'h70);
    wrReg(8'h00, 0);
    wrReg(8'h0A, 8'h20);
    ticks(HALF - 1, 1'b0);
    tickEn = 1'b1;
    wrReg(8'h00, 8'hE8);
    tickEn = 1'b0;
    check("R8 write wins", int'(seconds), 40);
    check("R8 pulse still fires", int'(updatePulse), 1);

    // R9 low nibble storage, bit 7 reads 0, no timing effect
    wrReg(8'h0A, 8'hFF);
    wrReg(8'h00, 7);
    wrReg(8'h0A, 8'hAB);
    rdReg(8'h0A, rd); check("R9 ctrl readback", rd, 8'h2B);
    ticks(HALF - 1, 1'b0);
    check("R9 nibble no effect early", int'(seconds), 7);
    ticks(1, 1'b0);
    check("R9 nibble no effect update", int'(seconds), 8);

    // R10 unmapped index
    wrReg(8'h05, 8'hFF);
    rdReg(8'h05, rd); check("R10 unmapped read", rd, 0);
    rdReg(8'h0A, rd); check("R10 ctrl untouched", rd, 8'h2B);
    rdReg(8'h00, rd); check("R10 seconds untouched", rd, 8);

    finishRun();
  end

endmodule